// File: doc/BRIEF.md
# Input-Change Interrupt Controller with Timestamp

This block watches a bank of slow, asynchronous switch inputs and raises a level interrupt request towards a processor whenever the sampled input vector differs from its value one cycle earlier. Each input bit first passes through a synchroniser. A comparison against the previous synchronised sample then sets a sticky pending flag. The flag stays set until software acknowledges it. An enable bit gates the flag onto the interrupt line.

A free-running timestamp counter advances once per clock and wraps to zero. An interrupt handler reads it together with the input state to record when an event was serviced. Every register is reached through a simple single-cycle register port: a write strobe, an address and write data. Read data is registered and always reflects the address presented one cycle earlier.

The address map is: 0 input state, 1 timestamp, 2 enable, 3 pending status, 4 acknowledge. Addresses 5 to 7 are unmapped.

Top module: `chgirq_top`

## Requirements
- R1: Each switch input passes through a two-stage synchroniser. Address 0 reads the synchronised state, zero-extended. The new value appears on `reg_rdata` three clock edges after the input changes, while the address is held at 0.
- R2: A change in any bit of the synchronised state sets the pending flag on the third clock edge after the input change.
- R3: The pending flag is sticky. It stays set through further input changes and idle cycles until it is acknowledged.
- R4: Writing to address 4 with bit 0 = 1 clears pending at that write's clock edge. A write to address 4 with bit 0 = 0 has no effect. Address 4 reads as 0.
- R5: If an acknowledge and a detected change fall in the same cycle, pending stays set.
- R6: The enable register at address 2 keeps bit 0 of a write and reads it back in bit 0. All other bits read 0. Reset clears it.
- R7: `irq_o` equals pending AND enable. Pending still records changes while enable is 0. Setting enable while pending is set raises `irq_o` at the write's clock edge.
- R8: The timestamp at address 1 increments by one on every clock edge and wraps from all-ones to 0. It is TS_W bits wide, zero-extended.
- R9: Address 3 reads pending in bit 0 and is read-only. Writes to it change nothing.
- R10: After reset, `irq_o` is 0 and addresses 0, 2, 3, 4 and the unmapped addresses 5 to 7 all read 0. Reads of unmapped addresses always return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_i | input | IN_W | Asynchronous switch inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address, used for both reads and writes |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Level interrupt request |

## Verification
An input change reaches both `irq_o` and the state read data on the third clock edge after it is driven. A register write takes effect at its own edge, so `irq_o` responds at once, and a read of the affected register returns the new value one edge later. The bench drives inputs just after a falling edge, counts rising edges explicitly and samples on the following falling edge. It checks the edge before each result is due as well as the edge it is due, so a stage added or dropped shows up as a mismatch. The acknowledge that collides with a change is placed so that it is sampled on exactly the edge at which the change is detected.

// File: rtl/chgirq_pkg.sv
package chgirq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_STATE  = 3'd0,
    RA_TSTAMP = 3'd1,
    RA_ENABLE = 3'd2,
    RA_PEND   = 3'd3,
    RA_ACK    = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/chgirq_sync.sv
module chgirq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] state_o,
  output logic         change_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= '0;
          else     stage_q[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= '0;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stage_q[STAGES-1];
  end

  assign state_o  = stage_q[STAGES-1];
  assign change_o = (stage_q[STAGES-1] != prev_q);
endmodule

// File: rtl/chgirq_tstamp.sv
module chgirq_tstamp #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] count_o
);
  logic [TS_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  AST_TS_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '1) |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/chgirq_ctrl.sv
module chgirq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic change_i,
  input  logic en_we_i,
  input  logic en_wd_i,
  input  logic ack_i,
  output logic enable_o,
  output logic pend_o,
  output logic irq_o
);
  logic en_q;
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst)          en_q <= 1'b0;
    else if (en_we_i) en_q <= en_wd_i;
  end

  // a fresh change wins over a simultaneous acknowledge
  always_ff @(posedge clk) begin
    if (rst)           pend_q <= 1'b0;
    else if (change_i) pend_q <= 1'b1;
    else if (ack_i)    pend_q <= 1'b0;
  end

  assign enable_o = en_q;
  assign pend_o   = pend_q;
  assign irq_o    = pend_q & en_q;

  AST_CHANGE_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
    change_i |=> pend_q); // R2
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !ack_i) |=> pend_q); // R3
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !change_i) |=> !pend_q); // R4
  AST_NO_SPURIOUS_PEND: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !$past(pend_q)) |-> $past(change_i)); // R5
endmodule

// File: rtl/chgirq_top.sv
module chgirq_top #(
  parameter int IN_W   = 8,
  parameter int TS_W   = 32,
  parameter int DATA_W = 32,
  parameter int SYNC_N = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [IN_W-1:0]            sw_i,
  input  logic                       reg_we,
  input  logic [chgirq_pkg::ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  output logic                       irq_o
);
  import chgirq_pkg::*;

  logic [IN_W-1:0] state;
  logic            change;
  logic [TS_W-1:0] tstamp;
  logic            enable;
  logic            pend;
  logic            en_we;
  logic            ack;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  chgirq_sync #(.W(IN_W), .STAGES(SYNC_N)) sync_i (
    .clk(clk), .rst(rst), .async_i(sw_i), .state_o(state), .change_o(change)
  );

  chgirq_tstamp #(.TS_W(TS_W)) ts_i (
    .clk(clk), .rst(rst), .count_o(tstamp)
  );

  assign en_we = reg_we && (reg_addr == RA_ENABLE);
  assign ack   = reg_we && (reg_addr == RA_ACK) && reg_wdata[0];

  chgirq_ctrl ctrl_i (
    .clk(clk), .rst(rst), .change_i(change), .en_we_i(en_we),
    .en_wd_i(reg_wdata[0]), .ack_i(ack),
    .enable_o(enable), .pend_o(pend), .irq_o(irq_o)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      RA_STATE:  rd_mux[IN_W-1:0] = state;
      RA_TSTAMP: rd_mux[TS_W-1:0] = tstamp;
      RA_ENABLE: rd_mux[0]        = enable;
      RA_PEND:   rd_mux[0]        = pend;
      default:   rd_mux           = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;

  AST_IRQ_DROPS_ON_DISABLE: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == RA_ENABLE && !reg_wdata[0]) |=> !irq_o); // R7
endmodule

// File: tb/chgirq_top_tb.sv
module chgirq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W = 8;
  localparam int TS_W = 8;
  localparam int DW   = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [IN_W-1:0] sw;
  logic          we;
  logic [2:0]    addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chgirq_top #(.IN_W(IN_W), .TS_W(TS_W), .DATA_W(DW), .SYNC_N(2)) dut_i (
    .clk(clk), .rst(rst), .sw_i(sw), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    addr = a;
    tick();
    d = rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    logic [DW-1:0] prev_ts;
    logic [IN_W-1:0] prev_sw;
    bit wrapped;
    rst = 1'b1; sw = '0; we = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    check("R10 irq", {31'b0, irq}, 32'd0);
    for (int a = 0; a < 8; a++) begin
      if (a != 1) begin
        rd(a[2:0], v);
        check("R10 reset read", v, 32'd0);
      end
    end

    // R6 enable register
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); check("R6 enable readback", v, 32'd1);
    wr(3'd2, 32'h0000_0000);
    rd(3'd2, v); check("R6 enable cleared", v, 32'd0);
    wr(3'd2, 32'h0000_0001);

    // R1/R2 latency: result due on third edge
    addr = 3'd0; sw = 8'h01;
    tick(); check("R1 state edge1", rdata, 32'd0);
    tick(); check("R1 state edge2", rdata, 32'd0);
    check("R2 irq before due", {31'b0, irq}, 32'd0);
    tick(); check("R1 state edge3", rdata, 32'd1);
    check("R2 irq due", {31'b0, irq}, 32'd1);

    // R3 sticky through more changes
    sw = 8'h03; repeat (6) tick();
    check("R3 sticky", {31'b0, irq}, 32'd1);
    // R4 ack with bit0 = 0 has no effect
    wr(3'd4, 32'hFFFF_FFFE);
    check("R4 ack bit0=0", {31'b0, irq}, 32'd1);
    // R9 pending is read-only
    wr(3'd3, 32'd0);
    rd(3'd3, v); check("R9 pend write ignored", v, 32'd1);
    rd(3'd4, v); check("R4 ack reads zero", v, 32'd0);
    wr(3'd4, 32'd1);
    check("R4 ack clears irq", {31'b0, irq}, 32'd0);
    rd(3'd3, v); check("R4 pend cleared", v, 32'd0);

    // R7 pending recorded while disabled
    wr(3'd2, 32'd0);
    sw = 8'h07; repeat (4) tick();
    check("R7 irq masked", {31'b0, irq}, 32'd0);
    rd(3'd3, v); check("R7 pend while masked", v, 32'd1);
    wr(3'd2, 32'd1);
    check("R7 enable raises irq", {31'b0, irq}, 32'd1);
    wr(3'd4, 32'd1);
    check("R7 cleared", {31'b0, irq}, 32'd0);

    // R5 ack collides with a detected change
    sw = 8'h0F;
    tick(); tick();
    we = 1'b1; addr = 3'd4; wdata = 32'd1;
    tick();
    we = 1'b0; wdata = '0;
    check("R5 change beats ack", {31'b0, irq}, 32'd1);
    wr(3'd4, 32'd1);
    check("R5 later ack clears", {31'b0, irq}, 32'd0);

    // R1/R2 sweep over every input value
    prev_sw = sw;
    for (int k = 0; k < 256; k++) begin
      logic [IN_W-1:0] nv;
      nv = k[IN_W-1:0] ^ 8'h5A;
      addr = 3'd0; sw = nv;
      tick(); tick(); tick();
      check("R1 sweep state", rdata, {24'd0, nv});
      check("R2 sweep irq", {31'b0, irq}, {31'b0, (nv != prev_sw)});
      wr(3'd4, 32'd1);
      prev_sw = nv;
    end
    check("R4 sweep end idle", {31'b0, irq}, 32'd0);

    // R8 timestamp steps by one and wraps
    rd(3'd1, prev_ts);
    wrapped = 0;
    for (int k = 0; k < 300; k++) begin
      tick();
      check("R8 ts step", rdata, {24'd0, 8'(prev_ts[7:0] + 8'd1)});
      if (rdata == 32'd0) wrapped = 1;
      prev_ts = rdata;
    end
    check("R8 ts wrapped", {31'b0, wrapped}, 32'd1);

    // R10 unmapped addresses stay zero in operation
    for (int a = 5; a < 8; a++) begin
      rd(a[2:0], v);
      check("R10 unmapped", v, 32'd0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule